// File: doc/BRIEF.md
# Interrupt Vector Status Resolver

This block answers reads of the two vector/status words of an interrupt controller: one for normal-class requests and one for fast-class requests. It receives the controller's pending, enable and fast-type vectors for 64 sources, together with a 4-bit priority for each source. On a normal read it finds the pending, enabled, normal-type source with the greatest priority and returns its number and priority packed into one word. On a fast read it returns the lowest-numbered pending, enabled, fast-type source.

A read has a side effect. When a source is returned, the block emits a one-cycle clear strobe that carries the source number, and the controller drops that pending bit. When nothing qualifies, the read returns all ones and no clear is issued. Read data, the valid flag and the clear strobe all appear in the cycle after a read is accepted. Only the rising edge of a read strobe starts an access, so a bus that holds the strobe high still produces exactly one access.

Top module: `vres_top`

## Requirements
- R1: A normal read considers only sources that are pending, enabled and not marked fast. Disabled sources and fast-type sources are never returned, whatever their priority.
- R2: A normal read returns the qualifying source with the greatest priority. When several qualifying sources share that priority, the highest-numbered one is returned.
- R3: The normal read word holds the source number in bits 31:16, zeros in bits 15:4 and the source's priority in bits 3:0.
- R4: A fast read returns the lowest-numbered source that is pending, enabled and marked fast, as its number zero-extended to 32 bits.
- R5: When no source qualifies, either read returns 0xFFFFFFFF and `clr_o` stays low.
- R6: A read is accepted in the cycle its strobe rises. In the next cycle `rvalid_o` is high for exactly one cycle with the read word. When a source was returned, `clr_o` is high in that same cycle for exactly one cycle, with `clr_idx_o` set to the returned source number.
- R7: A read strobe held high for several cycles is one access: it produces one `rvalid_o` pulse and at most one clear. A new access needs the strobe to go low first.
- R8: A priority of zero still qualifies, so a lone pending source with priority 0 is returned.
- R9: When both strobes rise in the same cycle, the normal read is served and the fast read is dropped.
- R10: After reset `rvalid_o` and `clr_o` are low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 64 | Pending bit per source |
| enab_i | input | 64 | Enable bit per source |
| fast_i | input | 64 | Fast-type bit per source |
| prio_i | input | 256 | 4-bit priority per source; source j sits in bits 4j+3:4j |
| rd_norm_i | input | 1 | Normal vector/status read strobe |
| rd_fast_i | input | 1 | Fast vector/status read strobe |
| rdata_o | output | 32 | Read word, valid while rvalid_o is high |
| rvalid_o | output | 1 | One-cycle read-data-valid pulse |
| clr_o | output | 1 | One-cycle pending-clear strobe |
| clr_idx_o | output | 6 | Source number to clear |

## Verification
The assertions assume that the pending and enable vectors seen at an accepted read are the ones the selection used. A clear strobe is checked against the pending and enable bits that were present one cycle earlier. The bench acts as the controller: it changes the pending and enable vectors only while no read is in flight, and it drops a pending bit only after the clear for that source has been seen. A reference model in the bench computes every expected word and strobe from its own scan of the sources and compares them with the outputs on every clock. Stimulus covers ties, zero priority, filtered sources, held strobes, simultaneous strobes and reads with nothing pending.

// File: rtl/vres_pkg.sv
package vres_pkg;

    localparam int SRC_N  = 64;
    localparam int PRIO_W = 4;
    localparam int IDX_W  = $clog2(SRC_N);
    localparam int DATA_W = 32;
    localparam int NUM_POS = 16;

    typedef enum logic {KIND_NORM, KIND_FAST} rd_kind_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } node_t;

    // b is the higher-numbered side: it wins ties
    function automatic node_t pick_node(node_t a, node_t b);
        if (b.valid && (!a.valid || b.prio >= a.prio))
            return b;
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] pack_norm(node_t n);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1:NUM_POS] = (DATA_W-NUM_POS)'(n.idx);
        w[PRIO_W-1:0]       = n.prio;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_fast(logic [IDX_W-1:0] idx);
        return DATA_W'(idx);
    endfunction

endpackage

// File: rtl/vres_norm_tree.sv
module vres_norm_tree
    import vres_pkg::*;
(
    input  logic [SRC_N-1:0]        qual_i,
    input  logic [SRC_N*PRIO_W-1:0] prio_i,
    output node_t                   best_o
);
    localparam int NODES = 2*SRC_N - 1;
    localparam int LEAF0 = SRC_N - 1;

    node_t nd [NODES];

    generate
        for (genvar j = 0; j < SRC_N; j++) begin : g_leaf
            assign nd[LEAF0+j] = '{valid: qual_i[j],
                                   idx:   IDX_W'(j),
                                   prio:  prio_i[j*PRIO_W +: PRIO_W]};
        end
        for (genvar i = 0; i < SRC_N-1; i++) begin : g_node
            assign nd[i] = pick_node(nd[2*i+1], nd[2*i+2]);
        end
    endgenerate

    assign best_o = nd[0];
endmodule

// File: rtl/vres_fast_find.sv
module vres_fast_find
    import vres_pkg::*;
(
    input  logic [SRC_N-1:0] qual_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int j = SRC_N-1; j >= 0; j--) begin
            if (qual_i[j]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/vres_top.sv
module vres_top
    import vres_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int PW    = PRIO_W,
    parameter int IW    = IDX_W,
    parameter int DW    = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [N_SRC-1:0]  enab_i,
    input  logic [N_SRC-1:0]  fast_i,
    input  logic [N_SRC*PW-1:0] prio_i,
    input  logic              rd_norm_i,
    input  logic              rd_fast_i,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o,
    output logic              clr_o,
    output logic [IW-1:0]     clr_idx_o
);
    logic [N_SRC-1:0] qual_norm, qual_fast;
    node_t            best_norm;
    logic             fast_found;
    logic [IW-1:0]    fast_idx;

    assign qual_norm = pend_i & enab_i & ~fast_i;
    assign qual_fast = pend_i & enab_i &  fast_i;

    vres_norm_tree u_norm (
        .qual_i (qual_norm),
        .prio_i (prio_i),
        .best_o (best_norm)
    );

    vres_fast_find u_fast (
        .qual_i  (qual_fast),
        .found_o (fast_found),
        .idx_o   (fast_idx)
    );

    logic     rd_any, rd_held, accept;
    rd_kind_e kind;
    logic     sel_found;
    logic [IW-1:0] sel_idx;
    logic [DW-1:0] sel_word;

    assign rd_any = rd_norm_i | rd_fast_i;
    assign accept = rd_any & ~rd_held;
    assign kind   = rd_norm_i ? KIND_NORM : KIND_FAST;

    always_comb begin
        unique case (kind)
            KIND_NORM: begin
                sel_found = best_norm.valid;
                sel_idx   = best_norm.idx;
                sel_word  = pack_norm(best_norm);
            end
            default: begin
                sel_found = fast_found;
                sel_idx   = fast_idx;
                sel_word  = pack_fast(fast_idx);
            end
        endcase
        if (!sel_found)
            sel_word = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_held   <= 1'b0;
            rvalid_o  <= 1'b0;
            clr_o     <= 1'b0;
            rdata_o   <= '0;
            clr_idx_o <= '0;
        end else begin
            rd_held  <= rd_any;
            rvalid_o <= accept;
            clr_o    <= accept & sel_found;
            if (accept) begin
                rdata_o   <= sel_word;
                clr_idx_o <= sel_idx;
            end
        end
    end
endmodule

// File: rtl/vres_chk.sv
module vres_chk
    import vres_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [SRC_N-1:0]         pend_i,
    input logic [SRC_N-1:0]         enab_i,
    input logic [SRC_N-1:0]         fast_i,
    input logic [SRC_N*PRIO_W-1:0]  prio_i,
    input logic                     rd_norm_i,
    input logic                     rd_fast_i,
    input logic [DATA_W-1:0]        rdata_o,
    input logic                     rvalid_o,
    input logic                     clr_o,
    input logic [IDX_W-1:0]         clr_idx_o
);
    AST_CLR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> !clr_o); // R6

    AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |=> !rvalid_o); // R7

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> $past(rd_norm_i || rd_fast_i)); // R6

    AST_CLR_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> rvalid_o && (rdata_o != '1)); // R5

    AST_EMPTY_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        (rvalid_o && rdata_o == '1) |-> !clr_o); // R5

    AST_CLR_IDX_IN_WORD: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> (rdata_o[DATA_W-1:NUM_POS] == (DATA_W-NUM_POS)'(clr_idx_o)
                   || rdata_o == DATA_W'(clr_idx_o))); // R3

    AST_CLR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> ((($past(pend_i & enab_i)) >> clr_idx_o) & SRC_N'(1)) != '0); // R1
endmodule

bind vres_top vres_chk u_chk (.*);

// File: tb/tb_vres_top.sv
module tb_vres_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pend = '0, enab = '0, fast = '0;
    logic [3:0]  prio [64];
    logic [255:0] prio_flat;
    logic        rn = 1'b0, rf = 1'b0;
    logic [31:0] rdata;
    logic        rvalid, clr;
    logic [5:0]  clr_idx;

    always #2 clk = ~clk;

    always_comb
        for (int j = 0; j < 64; j++) prio_flat[j*4 +: 4] = prio[j];

    vres_top dut (
        .clk(clk), .rst(rst), .pend_i(pend), .enab_i(enab), .fast_i(fast),
        .prio_i(prio_flat), .rd_norm_i(rn), .rd_fast_i(rf),
        .rdata_o(rdata), .rvalid_o(rvalid), .clr_o(clr), .clr_idx_o(clr_idx)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R10 reset";

    // reference model
    logic        e_valid, e_clr, prev_rd;
    logic [31:0] e_data;
    integer      e_idx;

    always @(posedge clk) begin
        if (rst) begin
            e_valid = 0; e_clr = 0; e_data = 0; e_idx = 0; prev_rd = 0;
        end else begin
            bit acc;
            acc = (rn || rf) && !prev_rd;
            prev_rd = rn || rf;
            e_valid = acc;
            e_clr = 0;
            if (acc) begin
                integer best, bi;
                best = -1; bi = -1;
                if (rn) begin
                    for (int i = 0; i < 64; i++)
                        if (pend[i] && enab[i] && !fast[i] && int'(prio[i]) >= best) begin
                            best = int'(prio[i]); bi = i;
                        end
                    if (bi >= 0) e_data = (bi << 16) | best;
                end else begin
                    for (int i = 63; i >= 0; i--)
                        if (pend[i] && enab[i] && fast[i]) bi = i;
                    if (bi >= 0) e_data = bi;
                end
                if (bi >= 0) begin e_clr = 1; e_idx = bi; end
                else e_data = 32'hFFFF_FFFF;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rvalid !== e_valid || clr !== e_clr ||
                (e_valid && rdata !== e_data) || (e_clr && clr_idx !== 6'(e_idx)) ||
                (rst == 0 && tag == "R10 reset" && rdata !== 32'h0)) begin
                errors++;
                $display("FAIL %s: valid=%0b clr=%0b data=%08h idx=%0d exp valid=%0b clr=%0b data=%08h idx=%0d",
                         tag, rvalid, clr, rdata, clr_idx, e_valid, e_clr, e_data, e_idx);
            end
        end
    end

    task automatic do_read(input bit n, input bit f, input int hold);
        bit c; integer ci;
        rn = n; rf = f;
        @(negedge clk);
        c = e_clr; ci = e_idx;
        repeat (hold-1) @(negedge clk);
        rn = 0; rf = 0;
        if (c) pend[ci] = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        pend = '0; enab = '0; fast = '0;
        for (int j = 0; j < 64; j++) prio[j] = 4'd0;
    endtask

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        tag = "R2 distinct priorities";
        prio[3] = 4'd5; prio[17] = 4'd11; prio[44] = 4'd2;
        enab[3] = 1; enab[17] = 1; enab[44] = 1;
        pend[3] = 1; pend[17] = 1; pend[44] = 1;
        repeat (3) do_read(1, 0, 1);

        tag = "R2 tie goes high-numbered";
        prio[5] = 4'd9; prio[20] = 4'd9; prio[40] = 4'd9;
        enab[5] = 1; enab[20] = 1; enab[40] = 1;
        pend[5] = 1; pend[20] = 1; pend[40] = 1;
        repeat (3) do_read(1, 0, 1);

        tag = "R1 disabled and fast filtered";
        prio[60] = 4'd15; pend[60] = 1; enab[60] = 0;
        prio[61] = 4'd15; pend[61] = 1; enab[61] = 1; fast[61] = 1;
        prio[9] = 4'd1; pend[9] = 1; enab[9] = 1;
        do_read(1, 0, 1);
        tag = "R5 normal empty";
        do_read(1, 0, 1);

        tag = "R4 fast lowest-numbered";
        fast[7] = 1; fast[3] = 1; fast[50] = 1;
        enab[7] = 1; enab[3] = 1; enab[50] = 1;
        pend[7] = 1; pend[3] = 1; pend[50] = 1;
        repeat (4) do_read(0, 1, 1);
        tag = "R5 fast empty";
        do_read(0, 1, 1);
        clear_all();

        tag = "R8 R3 zero priority";
        enab[12] = 1; pend[12] = 1;
        do_read(1, 0, 1);

        tag = "R7 held strobe";
        enab[30] = 1; pend[30] = 1; prio[30] = 4'd7;
        enab[31] = 1; pend[31] = 1; prio[31] = 4'd6;
        do_read(1, 0, 4);
        do_read(1, 0, 3);

        tag = "R9 simultaneous strobes";
        enab[2] = 1; pend[2] = 1; fast[2] = 1;
        enab[33] = 1; pend[33] = 1; prio[33] = 4'd3;
        do_read(1, 1, 1);
        do_read(0, 1, 1);
        clear_all();

        tag = "R2 R6 full population";
        for (int j = 0; j < 64; j++) begin
            enab[j] = 1; pend[j] = 1; fast[j] = (j % 5 == 0);
            prio[j] = 4'((j * 7) % 16);
        end
        repeat (20) do_read(1, 0, 1);
        repeat (6) do_read(0, 1, 1);

        tag = "R6 back-to-back reads";
        rn = 1; @(negedge clk); rn = 0; @(negedge clk); rn = 1; @(negedge clk); rn = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule